// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider

This block holds the digital counters of an integer-N frequency synthesizer whose channel grid is 1 MHz. In the master-clock domain a reference divider turns the crystal clock into a 1 MHz comparison pulse by dividing by R, which is the master frequency in MHz (typically 12, 13 or 16). In the oscillator domain a feedback path divides the oscillator clock by 32·N + A. A 32/33 dual-modulus prescaler runs at 33 for the first A of its cycles in each frame and at 32 for the other N − A cycles. N is a 7-bit count of prescaler cycles per frame. A is a 5-bit count of the cycles that run at 33.

With a 1 MHz comparison rate the locked oscillator sits at (32·N + A) MHz. For example, N = 75, A = 2 gives 2402 MHz and N = 78, A = 4 gives 2500 MHz. A receive local oscillator 2 MHz below the transmit channel, for a 2 MHz intermediate frequency, is obtained by programming the value two lower. For example, N = 74, A = 30 gives 2398 MHz.

Each divider takes new settings only when it closes a period, so no output period is ever cut short. A swallow value larger than N, or an N of zero, is refused: the previous settings stay in use and an error flag is raised. The phase detector, charge pump and analog loop lie outside the block. The oscillator clock is modelled as a digital clock.

Top module: `swallow_synth_div`

## Requirements
- R1: While a domain's synchronous active-low reset is asserted, its outputs are low (ref_pulse in the reference domain; fb_pulse, mod_hi and cfg_err in the oscillator domain). The first rising clock edge after release opens a period and raises that domain's pulse for one cycle.
- R2: ref_pulse is high for exactly one ref_clk cycle and repeats every R ref_clk rising edges. With R = 1 it stays high on every cycle.
- R3: A new cfg_r takes effect only at the edge that raises ref_pulse. A value of 0 is ignored and the previous divisor is kept.
- R4: fb_pulse is high for one vco_clk cycle and repeats every 32·N + A vco_clk rising edges. For example, N = 75, A = 2 gives 2402 edges and N = 78, A = 4 gives 2500 edges.
- R5: mod_hi is 1 (divide by 33) for exactly the first 33·A vco_clk edges after the edge that raises fb_pulse, and 0 (divide by 32) for the rest of the frame.
- R6: N and A are sampled at the edge that closes a frame. If A > N or N = 0 there, cfg_err goes high with fb_pulse and stays high until a frame boundary that samples a valid pair. Meanwhile the last accepted N and A are reused.
- R7: A new N and A take effect only at a frame boundary. A pair first present on the very edge that closes a frame governs the next frame.
- R8: With A = 0 the frame is 32·N edges and mod_hi stays 0. With A = N it is 33·N edges and mod_hi stays 1 across frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Master (crystal) clock |
| ref_rst_n | input | 1 | Synchronous active-low reset, reference domain |
| vco_clk | input | 1 | Oscillator clock, modelled as digital |
| vco_rst_n | input | 1 | Synchronous active-low reset, oscillator domain |
| cfg_r | input | R_W (5) | Reference divisor R, synchronous to ref_clk |
| cfg_n | input | N_W (7) | Prescaler cycles per frame N, synchronous to vco_clk |
| cfg_a | input | A_W (5) | Divide-by-33 cycles per frame A, synchronous to vco_clk |
| ref_pulse | output | 1 | One-cycle comparison pulse, reference domain |
| fb_pulse | output | 1 | One-cycle feedback pulse, oscillator domain |
| mod_hi | output | 1 | Prescaler modulus control: 1 = divide by 33, 0 = divide by 32 |
| cfg_err | output | 1 | Last sampled N/A pair was refused |

## Verification
In the oscillator domain, a settings change can coincide with the edge that closes a frame. On that edge the block reloads its counters, samples and checks N and A, updates cfg_err and may flip mod_hi.

The bench provokes this coincidence on purpose. It watches its own model's count of edges left in the frame and applies a new pair just before the closing edge. It does this with valid pairs, with A = N and A = 0, and with refused pairs.

The judgement is made cycle by cycle against a behavioural model. Every output must match in the cycle after the closing edge, and the next pulse must come exactly 32·N + A edges later. The reference domain is handled the same way, with R changes and R = 0 placed at random points inside a period.

// File: rtl/swallow_div_pkg.sv
// Shared constants and types for the pulse-swallow synthesizer divider.
package swallow_div_pkg;

    // Low modulus of the dual-modulus prescaler; the high modulus is one more.
    localparam int unsigned PRE_LO_DEF = 32;

    // Prescaler modulus selection as seen on the control line.
    typedef enum logic {
        MOD_BASE  = 1'b0,   // divide by PRE_LO
        MOD_PLUS1 = 1'b1    // divide by PRE_LO + 1
    } modulus_e;

endpackage

// File: rtl/ref_divider.sv
// Reference divider: divides ref_clk by R and emits a one-cycle pulse at the
// start of each period. Assumes cfg_r is synchronous to clk. A new R is taken
// only when a period closes; R = 0 is ignored and the held divisor reused.
module ref_divider #(
    parameter int unsigned R_W   = 5,
    parameter int unsigned R_RST = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [R_W-1:0] cfg_r,
    output logic           pulse
);

    logic [R_W-1:0] cnt;      // edges remaining before the next period start
    logic [R_W-1:0] r_hold;   // divisor in use
    logic [R_W-1:0] r_next;   // divisor chosen at a period boundary

    // Pick the requested divisor, or keep the held one when R is zero.
    always_comb begin
        r_next = (cfg_r != '0) ? cfg_r : r_hold;
    end

    // Count down one period and reload at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            r_hold <= R_W'(R_RST);
            pulse  <= 1'b0;
        end else if (cnt == '0) begin
            cnt    <= r_next - R_W'(1);
            r_hold <= r_next;
            pulse  <= 1'b1;
        end else begin
            cnt    <= cnt - R_W'(1);
            pulse  <= 1'b0;
        end
    end

endmodule

// File: rtl/dual_mod_prescaler.sv
// Dual-modulus prescaler: counts oscillator edges and flags the last edge of
// each cycle of PRE_LO or PRE_LO + 1 edges. The modulus must stay stable for a
// whole cycle; it is read when the count reaches its end.
module dual_mod_prescaler
    import swallow_div_pkg::*;
#(
    parameter int unsigned PRE_LO = PRE_LO_DEF
) (
    input  logic     clk,
    input  logic     rst_n,
    input  modulus_e modulus,
    output logic     tick
);

    localparam int unsigned PC_W = $clog2(PRE_LO + 1);
    localparam logic [PC_W-1:0] LAST_LO = PC_W'(PRE_LO - 1);
    localparam logic [PC_W-1:0] LAST_HI = PC_W'(PRE_LO);

    logic [PC_W-1:0] pc;     // edges seen in the current prescaler cycle
    logic [PC_W-1:0] last;   // terminal count for the current modulus

    // Terminal count from the selected modulus.
    always_comb begin
        last = (modulus == MOD_PLUS1) ? LAST_HI : LAST_LO;
        tick = (pc == last);
    end

    // Step the cycle counter; reset parks it on the final edge of a cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= LAST_LO;
        end else if (tick) begin
            pc <= '0;
        end else begin
            pc <= pc + PC_W'(1);
        end
    end

endmodule

// File: rtl/fb_cfg_guard.sv
// Feedback settings guard: a pair is usable when N is nonzero and the
// swallow count does not exceed N. Purely combinational.
module fb_cfg_guard #(
    parameter int unsigned N_W = 7,
    parameter int unsigned A_W = 5
) (
    input  logic [N_W-1:0] n_in,
    input  logic [A_W-1:0] a_in,
    output logic           usable
);

    localparam int unsigned CW = (N_W > A_W) ? N_W : A_W;

    logic [CW-1:0] n_ext;
    logic [CW-1:0] a_ext;

    // Widen both counts to a common width and test the pair.
    always_comb begin
        n_ext  = CW'(n_in);
        a_ext  = CW'(a_in);
        usable = (n_ext != '0) && (a_ext <= n_ext);
    end

endmodule

// File: rtl/swallow_ctrl.sv
// Programmable and swallow counters: on each prescaler tick they step through
// a frame of N prescaler cycles, the first A of them at the high modulus. At
// the frame's last tick they emit the feedback pulse and load the next pair,
// or reuse the last accepted pair if the guard refuses the new one.
module swallow_ctrl
    import swallow_div_pkg::*;
#(
    parameter int unsigned N_W   = 7,
    parameter int unsigned A_W   = 5,
    parameter int unsigned N_RST = 75,
    parameter int unsigned A_RST = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [N_W-1:0] cfg_n,
    input  logic [A_W-1:0] cfg_a,
    input  logic           usable,
    output modulus_e       modulus,
    output logic           fb_pulse,
    output logic           cfg_err
);

    logic [N_W-1:0] nc;      // prescaler cycles left in the frame, current included
    logic [A_W-1:0] ac;      // high-modulus cycles left in the frame
    logic [N_W-1:0] n_act;   // last accepted N
    logic [A_W-1:0] a_act;   // last accepted A
    logic           frame_end;

    // Modulus follows the swallow counter; frame ends on the last cycle's tick.
    always_comb begin
        modulus   = (ac != '0) ? MOD_PLUS1 : MOD_BASE;
        frame_end = tick && (nc <= N_W'(1));
    end

    // Step the counters per prescaler cycle and reload them at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nc       <= N_W'(1);
            ac       <= '0;
            n_act    <= N_W'(N_RST);
            a_act    <= A_W'(A_RST);
            fb_pulse <= 1'b0;
            cfg_err  <= 1'b0;
        end else if (frame_end) begin
            fb_pulse <= 1'b1;
            cfg_err  <= !usable;
            if (usable) begin
                nc    <= cfg_n;
                ac    <= cfg_a;
                n_act <= cfg_n;
                a_act <= cfg_a;
            end else begin
                nc    <= n_act;
                ac    <= a_act;
            end
        end else begin
            fb_pulse <= 1'b0;
            if (tick) begin
                nc <= nc - N_W'(1);
                if (ac != '0) begin
                    ac <= ac - A_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/swallow_synth_div.sv
// Top of the pulse-swallow synthesizer divider. The reference domain divides
// the master clock by R; the oscillator domain divides by 32*N + A through a
// dual-modulus prescaler and its two counters. cfg_r must be synchronous to
// ref_clk and cfg_n/cfg_a to vco_clk; the two domains share nothing.
module swallow_synth_div
    import swallow_div_pkg::*;
#(
    parameter int unsigned R_W    = 5,
    parameter int unsigned N_W    = 7,
    parameter int unsigned A_W    = 5,
    parameter int unsigned PRE_LO = PRE_LO_DEF,
    parameter int unsigned R_RST  = 13,
    parameter int unsigned N_RST  = 75,
    parameter int unsigned A_RST  = 2
) (
    input  logic           ref_clk,
    input  logic           ref_rst_n,
    input  logic           vco_clk,
    input  logic           vco_rst_n,
    input  logic [R_W-1:0] cfg_r,
    input  logic [N_W-1:0] cfg_n,
    input  logic [A_W-1:0] cfg_a,
    output logic           ref_pulse,
    output logic           fb_pulse,
    output logic           mod_hi,
    output logic           cfg_err
);

    modulus_e modulus;
    logic     pre_tick;
    logic     pair_ok;

    ref_divider #(
        .R_W   (R_W),
        .R_RST (R_RST)
    ) u_ref (
        .clk   (ref_clk),
        .rst_n (ref_rst_n),
        .cfg_r (cfg_r),
        .pulse (ref_pulse)
    );

    dual_mod_prescaler #(
        .PRE_LO (PRE_LO)
    ) u_pre (
        .clk     (vco_clk),
        .rst_n   (vco_rst_n),
        .modulus (modulus),
        .tick    (pre_tick)
    );

    fb_cfg_guard #(
        .N_W (N_W),
        .A_W (A_W)
    ) u_guard (
        .n_in   (cfg_n),
        .a_in   (cfg_a),
        .usable (pair_ok)
    );

    swallow_ctrl #(
        .N_W   (N_W),
        .A_W   (A_W),
        .N_RST (N_RST),
        .A_RST (A_RST)
    ) u_ctrl (
        .clk      (vco_clk),
        .rst_n    (vco_rst_n),
        .tick     (pre_tick),
        .cfg_n    (cfg_n),
        .cfg_a    (cfg_a),
        .usable   (pair_ok),
        .modulus  (modulus),
        .fb_pulse (fb_pulse),
        .cfg_err  (cfg_err)
    );

    // Expose the modulus control as a plain bit.
    always_comb begin
        mod_hi = (modulus == MOD_PLUS1);
    end

endmodule

// File: rtl/swallow_div_chk.sv
// Checker for the oscillator domain of swallow_synth_div, attached by bind.
// Assumes cfg_n/cfg_a are synchronous to vco_clk.
module swallow_div_chk #(
    parameter int unsigned N_W    = 7,
    parameter int unsigned A_W    = 5,
    parameter int unsigned PRE_LO = 32
) (
    input logic           vco_clk,
    input logic           vco_rst_n,
    input logic [N_W-1:0] cfg_n,
    input logic [A_W-1:0] cfg_a,
    input logic           fb_pulse,
    input logic           mod_hi,
    input logic           cfg_err
);

    logic [15:0] gap;    // edges since the last feedback pulse, saturating
    logic        seen;   // a feedback pulse has been observed since reset

    // Track the distance between feedback pulses.
    always_ff @(posedge vco_clk) begin
        if (!vco_rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (fb_pulse) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != 16'hFFFF) begin
            gap  <= gap + 16'd1;
        end
    end

    // R4
    fb_single_chk: assert property (@(posedge vco_clk) disable iff (!vco_rst_n)
        fb_pulse |=> !fb_pulse);

    // R4
    fb_min_period_chk: assert property (@(posedge vco_clk) disable iff (!vco_rst_n)
        (fb_pulse && seen) |-> (int'(gap) >= int'(PRE_LO) - 1));

    // R5
    mod_rise_at_frame_chk: assert property (@(posedge vco_clk) disable iff (!vco_rst_n)
        $rose(mod_hi) |-> fb_pulse);

    // R6
    err_moves_at_frame_chk: assert property (@(posedge vco_clk) disable iff (!vco_rst_n)
        !$stable(cfg_err) |-> fb_pulse);

    // R6
    err_matches_pair_chk: assert property (@(posedge vco_clk) disable iff (!vco_rst_n)
        fb_pulse |-> (cfg_err == (($past(cfg_n) == '0) ||
                                  (int'($past(cfg_a)) > int'($past(cfg_n))))));

endmodule

bind swallow_synth_div swallow_div_chk #(
    .N_W    (N_W),
    .A_W    (A_W),
    .PRE_LO (PRE_LO)
) u_chk (
    .vco_clk   (vco_clk),
    .vco_rst_n (vco_rst_n),
    .cfg_n     (cfg_n),
    .cfg_a     (cfg_a),
    .fb_pulse  (fb_pulse),
    .mod_hi    (mod_hi),
    .cfg_err   (cfg_err)
);

// File: tb/sim_swallow_synth_div.sv
// Bench for swallow_synth_div: behavioural per-edge models of both domains,
// compared against the outputs on every falling clock edge.
module sim_swallow_synth_div;

    localparam int R_RST = 13;
    localparam int N_RST = 75;
    localparam int A_RST = 2;

    logic       ref_clk = 1'b0;
    logic       vco_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [4:0] cfg_r   = 5'd12;
    logic [6:0] cfg_n   = 7'd75;
    logic [4:0] cfg_a   = 5'd2;
    logic       ref_pulse, fb_pulse, mod_hi, cfg_err;

    int vectors = 0;
    int errors  = 0;
    bit armed   = 1'b0;
    bit done    = 1'b0;
    string ph   = "R4";

    // model state
    int r_left = 1, r_hold = R_RST; bit e_ref = 0;
    int m_left = 1, m_n = N_RST, m_a = A_RST, m_pos = 0;
    bit started = 0, e_fb = 0, e_mod = 0, e_err = 0;

    always #5 ref_clk = ~ref_clk;   // 100 MHz
    always #2 vco_clk = ~vco_clk;

    swallow_synth_div u0 (
        .ref_clk   (ref_clk),
        .ref_rst_n (rst_n),
        .vco_clk   (vco_clk),
        .vco_rst_n (rst_n),
        .cfg_r     (cfg_r),
        .cfg_n     (cfg_n),
        .cfg_a     (cfg_a),
        .ref_pulse (ref_pulse),
        .fb_pulse  (fb_pulse),
        .mod_hi    (mod_hi),
        .cfg_err   (cfg_err)
    );

    // Reference-domain model, one step per rising edge.
    always @(posedge ref_clk) begin
        if (!rst_n) begin
            r_left = 1; r_hold = R_RST; e_ref = 0;
        end else if (r_left == 1) begin
            e_ref = 1;
            if (cfg_r != 0) r_hold = cfg_r;
            r_left = r_hold;
        end else begin
            e_ref = 0;
            r_left = r_left - 1;
        end
    end

    // Oscillator-domain model, one step per rising edge.
    always @(posedge vco_clk) begin
        if (!rst_n) begin
            m_left = 1; m_n = N_RST; m_a = A_RST; m_pos = 0;
            started = 0; e_fb = 0; e_err = 0;
        end else if (m_left == 1) begin
            e_fb = 1;
            if (cfg_n != 0 && cfg_a <= cfg_n) begin
                m_n = cfg_n; m_a = cfg_a; e_err = 0;
            end else begin
                e_err = 1;
            end
            m_left = 32 * m_n + m_a;
            m_pos = 0;
            started = 1;
        end else begin
            e_fb = 0;
            m_left = m_left - 1;
            m_pos = m_pos + 1;
        end
        e_mod = started && (m_pos < 33 * m_a);
    end

    task automatic check_bit(string tag, string name, logic got, bit exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %b expected %0b at %0t", tag, name, got, exp, $time);
        end
    endtask

    // Compare reference domain away from its active edge.
    always @(negedge ref_clk) begin
        if (armed) check_bit(rst_n ? "R2 R3" : "R1", "ref_pulse", ref_pulse, e_ref);
    end

    // Compare oscillator domain away from its active edge.
    always @(negedge vco_clk) begin
        if (armed) begin
            check_bit(rst_n ? ph : "R1", "fb_pulse", fb_pulse, e_fb);
            check_bit(rst_n ? "R5" : "R1", "mod_hi", mod_hi, e_mod);
            check_bit(rst_n ? "R6" : "R1", "cfg_err", cfg_err, e_err);
        end
    end

    task automatic frames(int k);
        repeat (k) @(posedge fb_pulse);
        @(negedge vco_clk);
    endtask

    // Apply a pair so it is present on the edge that closes the frame.
    task automatic set_at_boundary(int n, int a);
        @(negedge vco_clk);
        while (m_left != 1) @(negedge vco_clk);
        cfg_n = 7'(n); cfg_a = 5'(a);
    endtask

    task automatic set_mid(int n, int a);
        repeat (517) @(negedge vco_clk);
        cfg_n = 7'(n); cfg_a = 5'(a);
    endtask

    // Reference stimulus: R changes mid-period, R = 1, R = 0 ignored.
    initial begin : ref_stim
        @(posedge rst_n);
        repeat (40) @(negedge ref_clk);
        cfg_r = 5'd13;                      // R3 mid-period change
        repeat (57) @(negedge ref_clk);
        cfg_r = 5'd16;
        repeat (70) @(negedge ref_clk);
        cfg_r = 5'd1;                       // R2 continuous pulse
        repeat (9) @(negedge ref_clk);
        cfg_r = 5'd5;
        repeat (23) @(negedge ref_clk);
        cfg_r = 5'd0;                       // R3 zero is ignored
        repeat (41) @(negedge ref_clk);
        cfg_r = 5'd12;
        while (!done) @(negedge ref_clk);
    end

    // Oscillator stimulus and end of run.
    initial begin : fb_stim
        repeat (3) @(negedge vco_clk);
        armed = 1'b1;                       // R1 checks in reset
        repeat (4) @(negedge vco_clk);
        #1 rst_n = 1'b1;
        ph = "R4";  frames(3);              // 75/2 -> 2402
        ph = "R7";  set_mid(78, 4);  frames(3);   // mid-frame change -> 2500
        ph = "R7";  set_at_boundary(74, 30); frames(2); // 2398 on closing edge
        ph = "R8";  set_at_boundary(75, 0);  frames(2); // A = 0 -> 2400
        ph = "R8";  set_mid(5, 5);   frames(3);   // A = N -> 165
        ph = "R6";  set_at_boundary(3, 5);   frames(2); // refused, holds 5/5
        ph = "R6";  set_mid(0, 0);   frames(2);   // N = 0 refused
        ph = "R4";  set_at_boundary(1, 1);   frames(3); // 33
        ph = "R8";  set_mid(2, 0);   frames(3);   // 64
        ph = "R4";  set_mid(7, 3);   frames(3);   // 227
        repeat (20) @(negedge vco_clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin : watchdog
        #1500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog R4 got no completion expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule